// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This block is an 8-bit up-counter that advances on enables from a binary-weighted clock prescaler. One compare register (the period register) can restart the count, which makes the counting period programmable. A second compare register (the action register) drives a single output pin. It either applies a 2-bit action code on each match, or produces a pulse-width-modulated waveform whose period comes from the period register.

Software writes three byte-wide registers through a synchronous write port: control at address 0, action compare at address 1 and period compare at address 2. The pin is driven only while the external direction enable is set and the pin is connected, either by a non-zero action code or by PWM mode. The current count is always visible on a readback port.

Top module: `pcm_timer`

## Requirements
- R1: After reset the control byte, both compare registers, the count and the pin latch are zero, so the counter is stopped (count stays 0x00) and both `pin_oe` and `pin_o` are 0.
- R2: Control bits 3:0 select the count rate. Code 0 stops the counter, code 1 advances it every clock, and code k (2..15) advances it once every 2^(k-1) clocks. A 14-bit prescaler counts every clock from reset, and with division D the count advances at the edge that ends a cycle in which that prescaler value mod D equals D-1.
- R3: With control bits 7 and 6 both clear, the count increments by one per advance and wraps from 0xFF to 0x00.
- R4: With control bit 7 set, an advance taken while the count equals the period register loads 0x00 instead of incrementing.
- R5: With control bits 7 and 6 clear, a count equal to the period register has no effect and the next advance increments it.
- R6: With bit 6 clear, an advance taken while the count equals the action register applies control bits 5:4 to the pin latch: 00 leaves it unchanged, 01 inverts it, 10 clears it, 11 sets it.
- R7: `pin_oe` is 1 exactly when `pin_dir` is 1 and either bits 5:4 are non-zero or bit 6 is set. `pin_o` is the pin latch ANDed with `pin_oe`.
- R8: With control bit 6 set, an advance at the period register value restarts the count at 0x00 and sets the pin latch. Otherwise an advance at the action register value clears the latch. When both values match, the restart takes priority.
- R9: In PWM mode an action value of 0x00 gives a high level lasting one count per period, and an action value above the period value keeps the pin high.
- R10: Compare matches act only on advancing cycles, so a stopped counter that rests on the action value changes neither the count nor the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 action compare, 2 period compare |
| wr_data | input | 8 | Write data |
| pin_dir | input | 1 | Pin direction enable (1 = drive) |
| count_o | output | 8 | Current count |
| pin_o | output | 1 | Output pin value |
| pin_oe | output | 1 | Output pin drive enable |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that register writes are ordinary single-cycle strobes, so every control change takes effect at one edge. The assertions do not rely on any particular ordering of writes and counts. The bench meets these assumptions by driving every input at the falling edge. It releases reset there as well, and it writes registers while the counter runs, so that mode changes land at arbitrary prescaler phases.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int PRESC_W = 14;
  localparam int SEL_W   = $clog2(PRESC_W + 2);
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPA = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPC = 2'd2;

  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TGL = 2'b01,
    ACT_CLR = 2'b10,
    ACT_SET = 2'b11
  } act_e;

  typedef struct packed {
    logic             clr_on_c;
    logic             pwm_en;
    act_e             act;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/pcm_prescaler.sv
module pcm_prescaler
  import pcm_pkg::*;
#(
  parameter int PW = PRESC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = PW + 2;

  logic [PW-1:0]   pcnt_q, pcnt_d;
  logic [NSEL-1:0] tick_vec;

  always_comb begin
    pcnt_d = pcnt_q + {{(PW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick_vec[0] = 1'b0;
  assign tick_vec[1] = 1'b1;

  generate
    for (genvar k = 2; k < NSEL; k++) begin : g_div
      assign tick_vec[k] = &pcnt_q[k-2:0];
    end
  endgenerate

  assign tick = tick_vec[sel];
endmodule

// File: rtl/pcm_count.sv
module pcm_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart_en,
  input  logic [CW-1:0] cmp_c,
  output logic [CW-1:0] count,
  output logic          restart_hit
);
  logic [CW-1:0] count_q, count_d;

  always_comb begin
    restart_hit = restart_en && (count_q == cmp_c);
    count_d     = count_q;
    if (tick) begin
      if (restart_hit) count_d = '0;
      else             count_d = count_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/pcm_outcmp.sv
module pcm_outcmp
  import pcm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pwm_en,
  input  act_e          act,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp_a,
  input  logic          restart_hit,
  output logic          pin_q
);
  logic pin_r, pin_d, match_a;

  always_comb begin
    match_a = (count == cmp_a);
    pin_d   = pin_r;
    if (tick) begin
      if (pwm_en) begin
        if (restart_hit)  pin_d = 1'b1;
        else if (match_a) pin_d = 1'b0;
      end else if (match_a) begin
        unique case (act)
          ACT_OFF: pin_d = pin_r;
          ACT_TGL: pin_d = ~pin_r;
          ACT_CLR: pin_d = 1'b0;
          ACT_SET: pin_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_r <= 1'b0;
    else        pin_r <= pin_d;
  end

  assign pin_q = pin_r;
endmodule

// File: rtl/pcm_timer.sv
module pcm_timer
  import pcm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              pin_dir,
  output logic [CNT_W-1:0]  count_o,
  output logic              pin_o,
  output logic              pin_oe
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmpa_q, cmpa_d, cmpc_q, cmpc_d;
  logic             tick, restart_hit, pin_q;

  always_comb begin
    ctrl_d = ctrl_q;
    cmpa_d = cmpa_q;
    cmpc_d = cmpc_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADR_CTRL: ctrl_d = ctrl_t'(wr_data[7:0]);
        ADR_CMPA: cmpa_d = wr_data;
        ADR_CMPC: cmpc_d = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpc_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmpa_q <= cmpa_d;
      cmpc_q <= cmpc_d;
    end
  end

  pcm_prescaler #(.PW(PRESC_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctrl_q.sel),
    .tick (tick)
  );

  pcm_count #(.CW(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .restart_en (ctrl_q.clr_on_c | ctrl_q.pwm_en),
    .cmp_c      (cmpc_q),
    .count      (count_o),
    .restart_hit(restart_hit)
  );

  pcm_outcmp #(.CW(CNT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pwm_en     (ctrl_q.pwm_en),
    .act        (ctrl_q.act),
    .count      (count_o),
    .cmp_a      (cmpa_q),
    .restart_hit(restart_hit),
    .pin_q      (pin_q)
  );

  assign pin_oe = pin_dir & (ctrl_q.pwm_en | (ctrl_q.act != ACT_OFF));
  assign pin_o  = pin_oe & pin_q;
endmodule

// File: rtl/pcm_timer_chk.sv
module pcm_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [3:0]       sel,
  input logic             clr_on_c,
  input logic             pwm_en,
  input logic [CNT_W-1:0] cmp_c,
  input logic [CNT_W-1:0] count_o,
  input logic             pin_q,
  input logic             pin_oe,
  input logic             pin_dir
);
  a_r2_stop_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'd0) |-> !tick);

  a_r10_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_o));

  a_r10_hold_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin_q));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_on_c && !pwm_en && count_o == {CNT_W{1'b1}}) |=> (count_o == '0));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_on_c && count_o == cmp_c) |=> (count_o == '0));

  a_r5_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_on_c && !pwm_en && count_o == cmp_c && cmp_c != {CNT_W{1'b1}})
      |=> (count_o == CNT_W'($past(cmp_c) + 1'b1)));

  a_r8_pwm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm_en && count_o == cmp_c) |=> (pin_q && count_o == '0));

  a_r7_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> pin_dir);
endmodule

bind pcm_timer pcm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .sel     (ctrl_q.sel),
  .clr_on_c(ctrl_q.clr_on_c),
  .pwm_en  (ctrl_q.pwm_en),
  .cmp_c   (cmpc_q),
  .count_o (count_o),
  .pin_q   (pin_q),
  .pin_oe  (pin_oe),
  .pin_dir (pin_dir)
);

// File: tb/pcm_timer_bench.sv
module pcm_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pin_dir = 1'b0;
  logic [7:0] count_o;
  logic       pin_o, pin_oe;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    live = 1'b0;
  string cur_req = "R1";

  // Independent behavioural model of the requirements
  logic [7:0]  m_ctrl = 8'd0, m_a = 8'd0, m_c = 8'd0, m_cnt = 8'd0;
  logic        m_q = 1'b0;
  logic [13:0] m_p = 14'd0;

  always #4 clk = ~clk;

  pcm_timer u_pcm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_dir(pin_dir), .count_o(count_o),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      automatic int  sel = int'(m_ctrl[3:0]);
      automatic int  div = (sel >= 2) ? (1 << (sel - 1)) : 1;
      automatic bit  tk  = (sel == 1) || (sel >= 2 && (int'(m_p) % div) == div - 1);
      automatic bit  rs  = (m_ctrl[7] || m_ctrl[6]) && (m_cnt == m_c);
      automatic bit  ma  = (m_cnt == m_a);
      if (tk) begin
        if (m_ctrl[6]) begin
          if (rs) m_q = 1'b1;
          else if (ma) m_q = 1'b0;
        end else if (ma) begin
          case (m_ctrl[5:4])
            2'b01: m_q = ~m_q;
            2'b10: m_q = 1'b0;
            2'b11: m_q = 1'b1;
            default: ;
          endcase
        end
        m_cnt = rs ? 8'd0 : m_cnt + 8'd1;
      end
      m_p = m_p + 14'd1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_ctrl = wr_data;
          2'd1: m_a = wr_data;
          2'd2: m_c = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && live && !done) begin
      automatic bit oe = pin_dir && (m_ctrl[6] || m_ctrl[5:4] != 2'b00);
      check({cur_req, " count"}, int'(count_o), int'(m_cnt));
      check({cur_req, " pin_oe"}, int'(pin_oe), int'(oe));
      check({cur_req, " pin_o"}, int'(pin_o), int'(oe && m_q));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    // R1: reset state, counter stopped
    check("R1 count", int'(count_o), 0);
    check("R1 pin_oe", int'(pin_oe), 0);
    check("R1 pin_o", int'(pin_o), 0);
    live = 1'b1;
    run(20);
    check("R1 stopped", int'(count_o), 0);

    // R3: free running wrap
    cur_req = "R3";
    wr(2'd0, 8'h01);
    run(600);

    // R2: every division code
    cur_req = "R2";
    for (int s = 2; s <= 15; s++) begin
      wr(2'd0, 8'(s));
      run(2 * (1 << (s - 1)) + 20);
    end

    // R4: clear on period compare, two rates
    cur_req = "R4";
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h81);
    run(100);
    wr(2'd2, 8'd2);
    wr(2'd0, 8'h83);
    run(100);

    // R5: period match ignored without clear
    cur_req = "R5";
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h01);
    run(600);

    // R6: each action code
    cur_req = "R6";
    pin_dir = 1'b1;
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd9);
    wr(2'd0, 8'hB1); run(40);
    wr(2'd0, 8'h91); run(40);
    wr(2'd0, 8'hA1); run(40);
    wr(2'd0, 8'h81); run(40);
    wr(2'd0, 8'hB1); run(15);
    wr(2'd0, 8'h81); run(30);
    wr(2'd0, 8'h91); run(40);

    // R7: direction enable gates drive
    cur_req = "R7";
    pin_dir = 1'b0;
    run(5);
    check("R7 oe off", int'(pin_oe), 0);
    run(20);
    pin_dir = 1'b1;
    run(5);
    check("R7 oe on", int'(pin_oe), 1);
    run(20);

    // R8: PWM, including A equal to C
    cur_req = "R8";
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h41);
    run(60);
    wr(2'd1, 8'd9);
    run(40);
    wr(2'd0, 8'h43);
    wr(2'd1, 8'd4);
    run(120);

    // R9: PWM corner values
    cur_req = "R9";
    wr(2'd0, 8'h41);
    wr(2'd1, 8'd0);
    run(60);
    wr(2'd1, 8'd12);
    run(60);
    check("R9 above period high", int'(pin_o), 1);

    // R10: stopped on the action value
    cur_req = "R10";
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h91);
    while (count_o != 8'd2) @(negedge clk);
    wr(2'd0, 8'h90);
    begin
      automatic logic hold_pin = pin_o;
      run(50);
      check("R10 count held", int'(count_o), 3);
      check("R10 pin held", int'(pin_o), int'(hold_pin));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule